// File: doc/BRIEF.md
# VLAN Table Command Engine

This block keeps a table of VLAN entries addressed by a 12-bit VLAN identifier. A host reaches the table only through three registers. It loads two data words, then writes a control word that holds a command code and a VID. That control write raises a busy flag. The engine carries out the access over a fixed number of cycles, set by a parameter. It then drops busy. A read leaves the entry in the data words and raises an invalid flag when the entry holds no valid VLAN.

Each entry has five parts:
- a valid bit
- an 8-port membership bitmap, where all ones means every port is a member
- an independent-learning flag
- a per-VLAN egress tag enable
- a 2-bit egress attribute for each port

A separate read-only lookup port serves the forwarding logic. It returns the entry for a VID one cycle after the VID is presented.

The table depth is a parameter that defaults to 1024 entries. A VID at or above the depth is unusable, as are VIDs 0 and 4095.

Top module: `vlan_tbl_engine`

## Requirements
- R1: A host write to the control register (address 0) while idle sets control bit 31 (busy). Busy then reads 1 for exactly CMD_LAT cycles and clears by itself.
- R2: The control register reads back busy at bit 31, invalid at bit 16, the command code at bits 15:12 and the VID at bits 11:0, with all other bits zero. Code 0 is read and code 1 is write. Any other code completes without changing the table or the data words, and leaves invalid at 0.
- R3: A write command stores both data words into the addressed entry in one step. Data word 1 (address 1) supplies valid at bit 0, membership at bits 23:16, egress tag enable at bit 28 and independent learning at bit 30. Data word 2 (address 2) supplies the attribute of port p at bits 2p+1:2p, coded 0 untagged, 2 tagged and 3 stacked. A membership of 0xFF is kept intact.
- R4: A read command loads both data words from the entry, using the R3 layout with all unused bits zero, in the same cycle that busy clears. Data words read back as last loaded or written.
- R5: After a read, control bit 16 is 1 if the entry's valid bit is clear and 0 if it is set. Issuing a new command clears it.
- R6: VIDs 0 and 4095, and VIDs at or above DEPTH, are unusable. A write to such a VID stores nothing and sets invalid. A read of such a VID returns zero data words and sets invalid.
- R7: While busy, host writes to the control and data registers are ignored.
- R8: After reset, every entry is invalid with zero contents, and all three registers read zero.
- R9: The lookup outputs show, one cycle after lk_vid_i, the entry for that VID. For an unusable VID they show all zeros.
- R10: When a command writes the entry that the lookup port is addressing in the same cycle, the lookup returns the newly written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 data word 1, 2 data word 2 |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| lk_vid_i | input | 12 | Lookup VID |
| lk_valid_o | output | 1 | Looked-up entry valid |
| lk_members_o | output | 8 | Looked-up membership bitmap |
| lk_ivl_o | output | 1 | Looked-up independent-learning flag |
| lk_vtag_o | output | 1 | Looked-up per-VLAN egress tag enable |
| lk_etag_o | output | 16 | Looked-up per-port egress attributes |

## Verification
A write followed by a read of the same VID uses data words padded with stray high bits. This checks that only the defined fields are stored and that the readback is zero elsewhere. Reads of entries never written, of entries written with valid clear, and of the unusable VIDs 0, 4095 and a VID at or above the depth each show a different cause of the invalid flag. Control and data writes issued back-to-back into the busy window, and an undefined command code, show whether the engine keeps the state it should. A lookup held on the VID being written shows whether the write takes priority in the same cycle. A stream of random commands then runs against a behavioural model.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
  localparam int NPORTS = 8;
  localparam int VID_W  = 12;
  localparam int ATTR_W = 2 * NPORTS;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_DATA1 = 2'd1;
  localparam logic [1:0] ADDR_DATA2 = 2'd2;

  localparam logic [3:0] CMD_READ  = 4'd0;
  localparam logic [3:0] CMD_WRITE = 4'd1;

  typedef struct packed {
    logic              ivl;
    logic              vtag;
    logic [NPORTS-1:0] members;
    logic [ATTR_W-1:0] attrs;
    logic              valid;
  } vtbl_entry_t;

  function automatic logic vid_usable(input logic [VID_W-1:0] vid, input int depth);
    return (vid != '0) && (vid != '1) && (int'(vid) < depth);
  endfunction

  function automatic vtbl_entry_t entry_of(input logic [31:0] w1, input logic [31:0] w2);
    vtbl_entry_t e;
    e.valid   = w1[0];
    e.members = w1[23:16];
    e.vtag    = w1[28];
    e.ivl     = w1[30];
    e.attrs   = w2[ATTR_W-1:0];
    return e;
  endfunction

  function automatic logic [31:0] word1_of(input vtbl_entry_t e);
    logic [31:0] w;
    w        = '0;
    w[0]     = e.valid;
    w[23:16] = e.members;
    w[28]    = e.vtag;
    w[30]    = e.ivl;
    return w;
  endfunction

  function automatic logic [31:0] word2_of(input vtbl_entry_t e);
    logic [31:0] w;
    w             = '0;
    w[ATTR_W-1:0] = e.attrs;
    return w;
  endfunction
endpackage

// File: rtl/vtbl_store.sv
module vtbl_store
  import vtbl_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VID_W-1:0] wvid_i,
  input  vtbl_entry_t      wentry_i,
  input  logic [VID_W-1:0] rvid_i,
  output vtbl_entry_t      rentry_o,
  input  logic [VID_W-1:0] lk_vid_i,
  output vtbl_entry_t      lk_entry_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  vtbl_entry_t mem_q [DEPTH];
  vtbl_entry_t lk_q;

  function automatic logic [IDX_W-1:0] vid_idx(input logic [VID_W-1:0] v);
    return v[IDX_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && vid_usable(wvid_i, DEPTH)) begin
      mem_q[vid_idx(wvid_i)] <= wentry_i;
    end
  end

  assign rentry_o = vid_usable(rvid_i, DEPTH) ? mem_q[vid_idx(rvid_i)] : '0;

  // host write wins over the stored copy on a same-entry collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_q <= '0;
    end else if (!vid_usable(lk_vid_i, DEPTH)) begin
      lk_q <= '0;
    end else if (we_i && (wvid_i == lk_vid_i)) begin
      lk_q <= wentry_i;
    end else begin
      lk_q <= mem_q[vid_idx(lk_vid_i)];
    end
  end

  assign lk_entry_o = lk_q;
endmodule

// File: rtl/vtbl_cmd_ctrl.sv
module vtbl_cmd_ctrl
  import vtbl_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int CMD_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic [VID_W-1:0] rd_vid_o,
  input  vtbl_entry_t      rd_entry_i,
  output logic             tbl_we_o,
  output logic [VID_W-1:0] tbl_vid_o,
  output vtbl_entry_t      tbl_entry_o,
  output logic             busy_o
);
  localparam int CNT_W = (CMD_LAT > 1) ? $clog2(CMD_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_LAT - 1);

  logic             busy_q, inv_q;
  logic [3:0]       func_q;
  logic [VID_W-1:0] vid_q;
  logic [31:0]      d1_q, d2_q;
  logic [CNT_W-1:0] cnt_q;
  logic             finish, usable;

  assign finish = busy_q && (cnt_q == CNT_LAST);
  assign usable = vid_usable(vid_q, DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
      func_q <= '0;
      vid_q  <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (finish) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        if (func_q == CMD_READ) begin
          d1_q  <= word1_of(rd_entry_i);
          d2_q  <= word2_of(rd_entry_i);
          inv_q <= !usable || !rd_entry_i.valid;
        end else if (func_q == CMD_WRITE) begin
          inv_q <= !usable;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        ADDR_CTRL: begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          inv_q  <= 1'b0;
          func_q <= reg_wdata_i[15:12];
          vid_q  <= reg_wdata_i[VID_W-1:0];
        end
        ADDR_DATA1: d1_q <= reg_wdata_i;
        ADDR_DATA2: d2_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o = {busy_q, 14'b0, inv_q, func_q, vid_q};
      ADDR_DATA1: reg_rdata_o = d1_q;
      ADDR_DATA2: reg_rdata_o = d2_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign rd_vid_o    = vid_q;
  assign tbl_vid_o   = vid_q;
  assign tbl_we_o    = finish && (func_q == CMD_WRITE) && usable;
  assign tbl_entry_o = entry_of(d1_q, d2_q);
  assign busy_o      = busy_q;
endmodule

// File: rtl/vlan_tbl_engine.sv
module vlan_tbl_engine
  import vtbl_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int CMD_LAT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic [11:0] lk_vid_i,
  output logic        lk_valid_o,
  output logic [7:0]  lk_members_o,
  output logic        lk_ivl_o,
  output logic        lk_vtag_o,
  output logic [15:0] lk_etag_o
);
  logic             busy, tbl_we;
  logic [VID_W-1:0] tbl_vid, rd_vid;
  vtbl_entry_t      tbl_entry, rd_entry, lk_entry;

  vtbl_cmd_ctrl #(.DEPTH(DEPTH), .CMD_LAT(CMD_LAT)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .rd_vid_o   (rd_vid),
    .rd_entry_i (rd_entry),
    .tbl_we_o   (tbl_we),
    .tbl_vid_o  (tbl_vid),
    .tbl_entry_o(tbl_entry),
    .busy_o     (busy)
  );

  vtbl_store #(.DEPTH(DEPTH)) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (tbl_we),
    .wvid_i    (tbl_vid),
    .wentry_i  (tbl_entry),
    .rvid_i    (rd_vid),
    .rentry_o  (rd_entry),
    .lk_vid_i  (lk_vid_i),
    .lk_entry_o(lk_entry)
  );

  assign lk_valid_o   = lk_entry.valid;
  assign lk_members_o = lk_entry.members;
  assign lk_ivl_o     = lk_entry.ivl;
  assign lk_vtag_o    = lk_entry.vtag;
  assign lk_etag_o    = lk_entry.attrs;
endmodule

// File: rtl/vtbl_checker.sv
module vtbl_checker
  import vtbl_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int CMD_LAT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [VID_W-1:0] lk_vid_i,
  input logic             lk_valid_o,
  input logic [7:0]       lk_members_o,
  input logic             busy,
  input logic             tbl_we,
  input logic [VID_W-1:0] tbl_vid,
  input vtbl_entry_t      tbl_entry
);
  int unsigned busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  a_r1_busy_on_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_CTRL && !busy) |=> busy);

  a_r1_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (busy_run < CMD_LAT));

  a_r7_ctrl_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && reg_we_i && reg_addr_i == ADDR_CTRL) |=> $stable(tbl_vid));

  a_r6_no_unusable_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |-> vid_usable(tbl_vid, DEPTH));

  a_r3_store_in_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |-> busy);

  a_r10_write_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we && lk_vid_i == tbl_vid) |=>
      (lk_members_o == $past(tbl_entry.members) && lk_valid_o == $past(tbl_entry.valid)));

  a_r9_unusable_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vid_usable(lk_vid_i, DEPTH) |=> (!lk_valid_o && lk_members_o == '0));
endmodule

bind vlan_tbl_engine vtbl_checker #(.DEPTH(DEPTH), .CMD_LAT(CMD_LAT)) i_vtbl_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .lk_vid_i    (lk_vid_i),
  .lk_valid_o  (lk_valid_o),
  .lk_members_o(lk_members_o),
  .busy        (busy),
  .tbl_we      (tbl_we),
  .tbl_vid     (tbl_vid),
  .tbl_entry   (tbl_entry)
);

// File: tb/test_vlan_tbl_engine.sv
`timescale 1ns/1ps
module test_vlan_tbl_engine;
  localparam int DEPTH = 1024;
  localparam int LAT   = 2;
  localparam logic [31:0] MASK1 = 32'h50FF_0001;
  localparam logic [31:0] MASK2 = 32'h0000_FFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [11:0] lk_vid_i = '0;
  logic        lk_valid_o, lk_ivl_o, lk_vtag_o;
  logic [7:0]  lk_members_o;
  logic [15:0] lk_etag_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vlan_tbl_engine #(.DEPTH(DEPTH), .CMD_LAT(LAT)) i_vlan_tbl_engine (.*);

  always #4 clk_i = ~clk_i;

  // behavioural model
  logic [31:0] tv1 [int];
  logic [31:0] tv2 [int];
  logic        m_busy = 0, m_inv = 0;
  int          m_cnt = 0;
  logic [3:0]  m_func = 0;
  logic [11:0] m_vid = 0;
  logic [31:0] m_d1 = 0, m_d2 = 0, m_lk = 0;

  function automatic bit usable(input logic [11:0] v);
    return v != 0 && v != 12'hFFF && int'(v) < DEPTH;
  endfunction
  function automatic logic [31:0] g1(input logic [11:0] v);
    return tv1.exists(int'(v)) ? tv1[int'(v)] : 32'h0;
  endfunction
  function automatic logic [31:0] g2(input logic [11:0] v);
    return tv2.exists(int'(v)) ? tv2[int'(v)] : 32'h0;
  endfunction
  function automatic logic [31:0] lk_pack(input logic [31:0] w1, input logic [31:0] w2);
    return {5'b0, w1[30], w1[28], w1[23:16], w2[15:0], w1[0]};
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      tv1.delete(); tv2.delete();
      m_busy = 0; m_inv = 0; m_cnt = 0; m_func = 0; m_vid = 0;
      m_d1 = 0; m_d2 = 0; m_lk = 0;
    end else begin
      if (m_busy) begin
        if (m_cnt == LAT - 1) begin
          if (m_func == 4'd0) begin
            m_d1  = usable(m_vid) ? g1(m_vid) : 32'h0;
            m_d2  = usable(m_vid) ? g2(m_vid) : 32'h0;
            m_inv = !usable(m_vid) || !m_d1[0];
          end else if (m_func == 4'd1) begin
            if (usable(m_vid)) begin
              tv1[int'(m_vid)] = m_d1 & MASK1;
              tv2[int'(m_vid)] = m_d2 & MASK2;
            end
            m_inv = !usable(m_vid);
          end
          m_busy = 0; m_cnt = 0;
        end else m_cnt++;
      end else if (reg_we_i) begin
        case (reg_addr_i)
          2'd0: begin m_busy = 1; m_cnt = 0; m_inv = 0;
                      m_func = reg_wdata_i[15:12]; m_vid = reg_wdata_i[11:0]; end
          2'd1: m_d1 = reg_wdata_i;
          2'd2: m_d2 = reg_wdata_i;
          default: ;
        endcase
      end
      m_lk = usable(lk_vid_i) ? lk_pack(g1(lk_vid_i), g2(lk_vid_i)) : 32'h0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lk_now();
    return {5'b0, lk_ivl_o, lk_vtag_o, lk_members_o, lk_etag_o, lk_valid_o};
  endfunction

  // per-clock comparison against the model
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      case (reg_addr_i)
        2'd0: chk("R1 ctrl", reg_rdata_o, {m_busy, 14'b0, m_inv, m_func, m_vid});
        2'd1: chk("R4 data1", reg_rdata_o, m_d1);
        2'd2: chk("R4 data2", reg_rdata_o, m_d2);
        default: chk("R2 unmapped", reg_rdata_o, 32'h0);
      endcase
      chk("R9 lookup", lk_now(), m_lk);
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic wait_idle();
    reg_addr_i = 2'd0;
    while (reg_rdata_o[31]) @(negedge clk_i);
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic cmd(input logic [3:0] f, input logic [11:0] v);
    reg_wr(2'd0, {16'b0, f, v});
    wait_idle();
  endtask

  task automatic wr_entry(input logic [11:0] v, input logic [31:0] w1, input logic [31:0] w2);
    reg_wr(2'd1, w1);
    reg_wr(2'd2, w2);
    cmd(4'd1, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    for (int a = 0; a < 3; a++) begin
      reg_addr_i = a[1:0]; #1;
      chk("R8 reset reg", reg_rdata_o, 32'h0);
    end
    rst_ni = 1;
    lk_vid_i = 12'd5;
    @(negedge clk_i); @(negedge clk_i);
    chk("R8 reset entry", lk_now(), 32'h0);

    // R3/R4: write then read with stray bits
    wr_entry(12'd5, 32'hDFFF_FF01, 32'hABCD_E7B2);
    @(negedge clk_i);
    chk("R3 lookup", lk_now(), {5'b0, 1'b1, 1'b1, 8'hFF, 16'hE7B2, 1'b1});
    reg_wr(2'd1, 32'h0); reg_wr(2'd2, 32'h0);
    cmd(4'd0, 12'd5);
    rd_reg(2'd0, r); chk("R2 ctrl readback", r, 32'h0000_0005);
    chk("R5 valid read", {31'b0, r[16]}, 32'h0);
    rd_reg(2'd1, r); chk("R4 data1", r, 32'h50FF_0001);
    rd_reg(2'd2, r); chk("R4 data2", r, 32'h0000_E7B2);

    // R5: never-written entry, and entry written invalid
    cmd(4'd0, 12'd6);
    rd_reg(2'd0, r); chk("R5 unwritten invalid", r, 32'h0001_0006);
    wr_entry(12'd7, 32'h0003_0000, 32'h0000_000E);
    cmd(4'd0, 12'd7);
    rd_reg(2'd0, r); chk("R5 cleared valid", r, 32'h0001_0007);
    rd_reg(2'd1, r); chk("R5 data1", r, 32'h0003_0000);

    // R6: unusable VIDs
    wr_entry(12'd0, 32'h00FF_0001, 32'h1);
    rd_reg(2'd0, r); chk("R6 write vid0", r, 32'h0001_1000);
    wr_entry(12'hFFF, 32'h00FF_0001, 32'h1);
    rd_reg(2'd0, r); chk("R6 write vid4095", r, 32'h0001_1FFF);
    wr_entry(12'd2000, 32'h00FF_0001, 32'h1);
    cmd(4'd0, 12'd2000);
    rd_reg(2'd0, r); chk("R6 read high vid", r, 32'h0001_07D0);
    rd_reg(2'd1, r); chk("R6 read zero", r, 32'h0);
    lk_vid_i = 12'hFFF;
    @(negedge clk_i); @(negedge clk_i);
    chk("R6 lookup unusable", lk_now(), 32'h0);

    // R7: writes during busy
    reg_wr(2'd1, 32'h0003_0001);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 2'd0; reg_wdata_i = 32'h0000_1014;
    @(negedge clk_i);
    reg_wdata_i = 32'h0000_0005;
    @(negedge clk_i);
    reg_addr_i = 2'd1; reg_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    reg_we_i = 0;
    wait_idle();
    rd_reg(2'd0, r); chk("R7 ctrl kept", r, 32'h0000_1014);
    rd_reg(2'd1, r); chk("R7 data kept", r, 32'h0003_0001);

    // R2: undefined code
    cmd(4'd5, 12'd5);
    rd_reg(2'd0, r); chk("R2 undefined code", r, 32'h0000_5005);
    rd_reg(2'd1, r); chk("R2 data untouched", r, 32'h0003_0001);

    // R10: lookup on entry being written
    lk_vid_i = 12'd9;
    reg_wr(2'd1, 32'h4081_0001);
    reg_wr(2'd2, 32'h0000_C003);
    cmd(4'd1, 12'd9);
    chk("R10 same-cycle write", lk_now(), {5'b0, 1'b1, 1'b0, 8'h81, 16'hC003, 1'b1});

    // R1: busy window length
    reg_wr(2'd0, 32'h0000_0009);
    reg_addr_i = 2'd0; #1;
    chk("R1 busy set", {31'b0, reg_rdata_o[31]}, 32'h1);
    wait_idle();

    // random traffic against the model
    for (int i = 0; i < 300; i++) begin
      logic [11:0] v;
      v = ($urandom % 4 == 0) ? 12'($urandom % 4096) : 12'(1 + $urandom % 15);
      lk_vid_i = 12'(1 + $urandom % 15);
      if ($urandom % 2) wr_entry(v, $urandom, $urandom);
      else cmd(4'($urandom % 3), v);
    end

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule